// File: doc/BRIEF.md
# Sharer-Vector Bit Operation Execute Stage

This block is the execute stage of a small in-order coprocessor that runs coherence protocol handlers. Its instruction set is built around directory sharer vectors. It can set or clear one bit of a 64-bit sharer word, branch on the state of one bit, and find the lowest sharer present. A dispatch operation turns an incoming message type into the start address of the handler for that type. The unit has no floating-point, multiply or divide hardware.

Each accepted instruction gives, one clock later, a result word, a branch-taken flag, a next-PC source code, the next PC itself, and a flag that says whether a find-first scan found any bit. The fetch logic upstream steers on the next-PC source code and the next PC.

Top module: `dir_bitop_unit`

## Requirements
- R1: Opcode 1 (set-bit) returns the operand with the addressed bit forced to 1 and every other bit unchanged.
- R2: Opcode 2 (clear-bit) returns the operand with the addressed bit forced to 0 and every other bit unchanged.
- R3: A bit position is taken from the low 6 bits of the 8-bit index field. Bits 7:6 of the field have no effect.
- R4: Opcode 3 (branch-if-set) branches when the addressed bit is 1, and opcode 4 (branch-if-clear) branches when it is 0. A taken branch sets taken=1, pc_sel=1 and next_pc=target. The result word is the unchanged operand.
- R5: A branch that is not taken gives taken=0, pc_sel=0 and next_pc=pc+1, which wraps modulo 2^12.
- R6: Opcode 5 (find-first) returns the position of the lowest set bit, zero-extended, with ffs_hit=1.
- R7: Find-first on an all-zero operand returns result 0 with ffs_hit=0.
- R8: Opcode 6 (dispatch) gives pc_sel=2 and next_pc = 0x100 + 0x40 × msg_type. The 4-bit message type selects one of 16 handler entries. The result is the operand and taken=0.
- R9: Opcodes 0 and 7 pass the operand through with taken=0, pc_sel=0 and next_pc=pc+1. ffs_hit is 0 for every opcode except 5.
- R10: Outputs are registered with one cycle of latency. out_valid follows in_valid one cycle later. When in_valid is low, every other output keeps its previous value.
- R11: Synchronous reset clears out_valid, result, taken, pc_sel, next_pc and ffs_hit to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| op | input | 3 | Opcode |
| opnd | input | 64 | Sharer-vector operand |
| bidx | input | 8 | Bit index field (low 6 bits used) |
| tgt | input | 12 | Branch target |
| pc | input | 12 | Address of the current instruction |
| msg_type | input | 4 | Incoming message type for dispatch |
| out_valid | output | 1 | Result present |
| result | output | 64 | Result word |
| taken | output | 1 | Branch taken |
| pc_sel | output | 2 | Next-PC source: 0 sequential, 1 branch, 2 dispatch |
| next_pc | output | 12 | Next instruction address |
| ffs_hit | output | 1 | Find-first found a set bit |

## Verification
The hardest cases to reach from the ports are those where the index field has its upper two bits set, and those where a sequential next PC wraps past 0xFFF. Both can hide inside an otherwise correct result. The vector table therefore includes set and branch instructions whose index field is 0xC5 or 0x43, and a not-taken branch at PC 0xFFF. Find-first gets an all-zero operand, an all-ones operand, a lone top bit, and a word whose lowest set bit sits below higher clusters, so that a scan that picks the highest bit cannot pass. A gap with in_valid low after a vector checks that the outputs hold.

// File: rtl/dir_bitop_unit.sv
module dir_bitop_unit #(
  parameter int W       = 64,
  parameter int IDXF_W  = 8,
  parameter int PC_W    = 12,
  parameter int MSG_W   = 4,
  parameter logic [11:0] HBASE   = 12'h100,
  parameter logic [11:0] HSTRIDE = 12'h040
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic [W-1:0]      opnd,
  input  logic [IDXF_W-1:0] bidx,
  input  logic [PC_W-1:0]   tgt,
  input  logic [PC_W-1:0]   pc,
  input  logic [MSG_W-1:0]  msg_type,
  output logic              out_valid,
  output logic [W-1:0]      result,
  output logic              taken,
  output logic [1:0]        pc_sel,
  output logic [PC_W-1:0]   next_pc,
  output logic              ffs_hit
);
  localparam int IW   = $clog2(W);
  localparam int NMSG = 1 << MSG_W;

  localparam logic [2:0] OP_SET = 3'd1, OP_CLR = 3'd2, OP_BRS = 3'd3,
                         OP_BRC = 3'd4, OP_FFS = 3'd5, OP_DSP = 3'd6;
  localparam logic [1:0] SEL_SEQ = 2'd0, SEL_BR = 2'd1, SEL_DSP = 2'd2;

  logic [PC_W-1:0] htbl [NMSG];
  for (genvar g = 0; g < NMSG; g++) begin : g_tbl
    assign htbl[g] = PC_W'(HBASE + HSTRIDE * g);
  end

  wire [IW-1:0]   pos  = bidx[IW-1:0];
  wire [W-1:0]    mask = {{(W-1){1'b0}}, 1'b1} << pos;
  wire            bit_on = |(opnd & mask);
  wire [PC_W-1:0] pc_inc = pc + 1'b1;

  logic [IW-1:0] ffs_pos;
  logic          ffs_any;
  always_comb begin
    ffs_pos = '0;
    ffs_any = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (opnd[i]) begin
        ffs_pos = IW'(i);
        ffs_any = 1'b1;
      end
    end
  end

  logic [W-1:0]    res_d;
  logic            tk_d, hit_d;
  logic [1:0]      sel_d;
  logic [PC_W-1:0] npc_d;
  always_comb begin
    res_d = opnd;
    tk_d  = 1'b0;
    hit_d = 1'b0;
    sel_d = SEL_SEQ;
    npc_d = pc_inc;
    case (op)
      OP_SET: res_d = opnd | mask;
      OP_CLR: res_d = opnd & ~mask;
      OP_BRS, OP_BRC: begin
        tk_d = (op == OP_BRS) ? bit_on : !bit_on;
        if (tk_d) begin
          sel_d = SEL_BR;
          npc_d = tgt;
        end
      end
      OP_FFS: begin
        res_d = W'(ffs_pos);
        hit_d = ffs_any;
      end
      OP_DSP: begin
        sel_d = SEL_DSP;
        npc_d = htbl[msg_type];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      taken     <= 1'b0;
      pc_sel    <= SEL_SEQ;
      next_pc   <= '0;
      ffs_hit   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= res_d;
        taken   <= tk_d;
        pc_sel  <= sel_d;
        next_pc <= npc_d;
        ffs_hit <= hit_d;
      end
    end
  end

  // R1
  set_bit_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && in_valid && op == OP_SET) |-> result[$past(bidx[IW-1:0])]);
  // R2
  clr_bit_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && in_valid && op == OP_CLR) |-> !result[$past(bidx[IW-1:0])]);
  // R6
  ffs_lowest_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && in_valid && op == OP_FFS) && ffs_hit |->
      ((($past(opnd) >> result[IW-1:0]) & 64'd1) == 64'd1) &&
      (($past(opnd) & ((64'd1 << result[IW-1:0]) - 64'd1)) == 64'd0));
  // R7
  ffs_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && in_valid && op == OP_FFS && opnd == '0) |-> !ffs_hit && result == '0);
  // R4
  br_target_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && in_valid) && taken |-> next_pc == $past(tgt) && pc_sel == SEL_BR);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !in_valid) |-> !out_valid && $stable(result) && $stable(next_pc));
endmodule

// File: tb/dir_bitop_unit_tb.sv
module dir_bitop_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [63:0] opnd = '0;
  logic [7:0]  bidx = '0;
  logic [11:0] tgt = '0, pc = '0;
  logic [3:0]  msg_type = '0;
  logic        out_valid, taken, ffs_hit;
  logic [63:0] result;
  logic [1:0]  pc_sel;
  logic [11:0] next_pc;

  always #10 clk = ~clk;

  dir_bitop_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .opnd(opnd),
    .bidx(bidx), .tgt(tgt), .pc(pc), .msg_type(msg_type),
    .out_valid(out_valid), .result(result), .taken(taken),
    .pc_sel(pc_sel), .next_pc(next_pc), .ffs_hit(ffs_hit)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [63:0] opnd;
    logic [7:0]  idx;
    logic [11:0] tgt;
    logic [11:0] pc;
    logic [3:0]  msg;
    logic [63:0] eres;
    logic        etk;
    logic [1:0]  esel;
    logic [11:0] enpc;
    logic        ehit;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 64'h0, 8'd0, 12'h000, 12'h010, 4'd0, 64'h1, 1'b0, 2'd0, 12'h011, 1'b0},
    '{3'd1, 64'h0, 8'd63, 12'h000, 12'h010, 4'd0, 64'h8000_0000_0000_0000, 1'b0, 2'd0, 12'h011, 1'b0},
    '{3'd1, 64'h0F, 8'hC5, 12'h000, 12'h020, 4'd0, 64'h2F, 1'b0, 2'd0, 12'h021, 1'b0},
    '{3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 8'd32, 12'h000, 12'h030, 4'd0, 64'hFFFF_FFFE_FFFF_FFFF, 1'b0, 2'd0, 12'h031, 1'b0},
    '{3'd2, 64'h1, 8'd1, 12'h000, 12'h030, 4'd0, 64'h1, 1'b0, 2'd0, 12'h031, 1'b0},
    '{3'd3, 64'h8, 8'd3, 12'h2A0, 12'h050, 4'd0, 64'h8, 1'b1, 2'd1, 12'h2A0, 1'b0},
    '{3'd3, 64'h8, 8'd2, 12'h2A0, 12'h050, 4'd0, 64'h8, 1'b0, 2'd0, 12'h051, 1'b0},
    '{3'd4, 64'h8, 8'd2, 12'h300, 12'hFFF, 4'd0, 64'h8, 1'b1, 2'd1, 12'h300, 1'b0},
    '{3'd4, 64'h8, 8'h43, 12'h300, 12'hFFF, 4'd0, 64'h8, 1'b0, 2'd0, 12'h000, 1'b0},
    '{3'd5, 64'h0000_0100_0000_0000, 8'd0, 12'h000, 12'h060, 4'd0, 64'd40, 1'b0, 2'd0, 12'h061, 1'b1},
    '{3'd5, 64'h8000_0000_0000_0000, 8'd0, 12'h000, 12'h060, 4'd0, 64'd63, 1'b0, 2'd0, 12'h061, 1'b1},
    '{3'd5, 64'hF0F0_0000_0000_0060, 8'd0, 12'h000, 12'h060, 4'd0, 64'd5, 1'b0, 2'd0, 12'h061, 1'b1},
    '{3'd5, 64'h0, 8'd0, 12'h000, 12'h060, 4'd0, 64'd0, 1'b0, 2'd0, 12'h061, 1'b0},
    '{3'd5, 64'hFFFF_FFFF_FFFF_FFFF, 8'd0, 12'h000, 12'h060, 4'd0, 64'd0, 1'b0, 2'd0, 12'h061, 1'b1},
    '{3'd6, 64'h55, 8'd0, 12'h000, 12'h020, 4'd0, 64'h55, 1'b0, 2'd2, 12'h100, 1'b0},
    '{3'd6, 64'h55, 8'd0, 12'h000, 12'h020, 4'd15, 64'h55, 1'b0, 2'd2, 12'h4C0, 1'b0},
    '{3'd6, 64'h55, 8'd0, 12'h000, 12'h020, 4'd7, 64'h55, 1'b0, 2'd2, 12'h2C0, 1'b0},
    '{3'd0, 64'hDEAD_BEEF_0123_4567, 8'd9, 12'h3FF, 12'h123, 4'd0, 64'hDEAD_BEEF_0123_4567, 1'b0, 2'd0, 12'h124, 1'b0},
    '{3'd7, 64'hDEAD_BEEF_0123_4567, 8'd9, 12'h3FF, 12'h123, 4'd0, 64'hDEAD_BEEF_0123_4567, 1'b0, 2'd0, 12'h124, 1'b0}
  };

  int checks = 0, fails = 0;
  bit done = 1'b0;

  function automatic string rtag(logic [2:0] o, logic [7:0] ix, logic tk);
    if (ix[7:6] != 2'b00) return "R3";
    case (o)
      3'd1: return "R1";
      3'd2: return "R2";
      3'd3, 3'd4: return tk ? "R4" : "R5";
      3'd5: return "R6/R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(vec_t v);
    in_valid = 1'b1; op = v.op; opnd = v.opnd; bidx = v.idx;
    tgt = v.tgt; pc = v.pc; msg_type = v.msg;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    // R11 reset state
    chk("R11", "out_valid", 64'(out_valid), 64'd0);
    chk("R11", "result", result, 64'd0);
    chk("R11", "taken/pc_sel/hit", {59'd0, taken, pc_sel, ffs_hit}, 64'd0);
    chk("R11", "next_pc", 64'(next_pc), 64'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string t;
      t = rtag(VEC[i].op, VEC[i].idx, VEC[i].etk);
      apply(VEC[i]);
      chk("R10", "out_valid", 64'(out_valid), 64'd1);
      chk(t, "result", result, VEC[i].eres);
      chk(t, "taken", 64'(taken), 64'(VEC[i].etk));
      chk(t, "pc_sel", 64'(pc_sel), 64'(VEC[i].esel));
      chk(t, "next_pc", 64'(next_pc), 64'(VEC[i].enpc));
      chk(t, "ffs_hit", 64'(ffs_hit), 64'(VEC[i].ehit));
    end

    // R10 hold: invalid cycle with different inputs leaves outputs alone
    apply(VEC[5]);
    in_valid = 1'b0; op = 3'd1; opnd = 64'hFFFF; bidx = 8'd40; pc = 12'h777;
    @(posedge clk); @(negedge clk);
    chk("R10", "out_valid low", 64'(out_valid), 64'd0);
    chk("R10", "result held", result, 64'h8);
    chk("R10", "next_pc held", 64'(next_pc), 64'h2A0);
    chk("R10", "taken held", 64'(taken), 64'd1);

    // R11 reset in mid-run
    apply(VEC[9]);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R11", "result after reset", result, 64'd0);
    chk("R11", "ffs_hit after reset", 64'(ffs_hit), 64'd0);
    rst = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule